// File: doc/BRIEF.md
# Trigger Completion DMA Request Generator

This block turns the completion of a trigger group's conversion chain into a DMA request. There are eight trigger groups by default. Each group has its own enable bit, a sticky request status bit and one request line toward the DMA controller. A completion event on an enabled group sets both the status bit and the request line. The DMA controller answers on a per-group acknowledge input.

Software reaches the block through a single 32-bit control word. A plain write port and a combinational read port give access to it. The word holds read/write enable bits, write-1-to-clear status bits and one global mode bit.

The mode bit decides what releases a raised request. In pulsed mode the acknowledge alone removes it. In latched mode the request stays up until two things are both true: an acknowledge has been seen for it, and its status bit has been cleared. The two may happen in either order. A synchronous soft reset returns all state to zero.

Top module: `trig_dma_req`

## Requirements
- R1: After the asynchronous reset, `rd_data` reads 0 and `dma_req` is 0.
- R2: A write stores `wr_data[7:0]` as the group enables (bit n for group n) and `wr_data[31]` as the mode bit (0 latched, 1 pulsed). Bits 15:8 and 30:24 read back as 0.
- R3: A `done_evt[n]` pulse on a group whose enable bit is 1 sets status bit 16+n of the control word and `dma_req[n]`, both visible one cycle later.
- R4: A `done_evt[n]` pulse on a group whose enable bit is 0 changes neither its status bit nor `dma_req[n]`.
- R5: A write with bit 16+n at 1 clears status bit n. A write with that bit at 0 leaves it unchanged.
- R6: When a completion event and a write-1-to-clear reach the same status bit in the same cycle, the bit stays set.
- R7: In latched mode, `dma_req[n]` falls at the first clock edge where an acknowledge has been seen since the request rose (in that cycle or earlier) and the status bit already reads 0. This holds whichever of acknowledge and clear comes first.
- R8: In pulsed mode, `dma_req[n]` falls at the clock edge where `dma_ack[n]` is sampled high. The status bit is not changed by the acknowledge.
- R9: `soft_rst` high at a clock edge clears every request line, status bit, enable bit and the mode bit.
- R10: An acknowledge that arrives while `dma_req[n]` is low is ignored. It does not count toward releasing a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all state |
| done_evt | input | 8 | Per-group conversion-chain completion pulse |
| dma_ack | input | 8 | Per-group acknowledge from the DMA controller |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| dma_req | output | 8 | Per-group DMA request line |

## Verification
The checker assumes that `done_evt` and `dma_ack` are synchronous to `clk` and act as one-cycle sampled levels. It also assumes that every write carries the whole intended control word, since enables and the mode bit are rewritten on every write.

The bench drives all inputs at the falling edge, so that every pulse covers exactly one rising edge. It always rewrites the current enable and mode values when it only means to clear status bits. Each sweep step returns the group under test to idle, with no request, no status bit and no stored acknowledge, before the next step starts.

// File: rtl/trig_dma_pkg.sv
package trig_dma_pkg;
  localparam int unsigned NUM_GRP  = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STAT_LSB = 16;
  localparam int unsigned MODE_POS = 31;
endpackage

// File: rtl/trig_dma_ctrl_reg.sv
module trig_dma_ctrl_reg #(
  parameter int unsigned GRPS     = trig_dma_pkg::NUM_GRP,
  parameter int unsigned WORD_W   = trig_dma_pkg::WORD_W,
  parameter int unsigned MODE_POS = trig_dma_pkg::MODE_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [GRPS-1:0]   en_q,
  output logic              mode_q
);
  logic [GRPS-1:0] en_d;
  logic            mode_d;
  logic            upd;

  // Clock enable: only a write or a soft reset moves these bits.
  assign upd = wr_en | soft_rst;

  always_comb begin
    if (soft_rst) begin
      en_d   = '0;
      mode_d = 1'b0;
    end else begin
      en_d   = wr_data[GRPS-1:0];
      mode_d = wr_data[MODE_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/trig_dma_lane.sv
module trig_dma_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic en,
  input  logic pulsed,
  input  logic evt,
  input  logic clr,
  input  logic ack,
  output logic stat_q,
  output logic req_q
);
  logic seen_q;
  logic stat_d, req_d, seen_d;
  logic set_evt, release_now, upd;

  assign set_evt = evt & en;
  // In latched mode the release needs a stored or present acknowledge and a cleared status bit.
  assign release_now = pulsed ? ack : ((seen_q | ack) & ~stat_q);
  assign upd = soft_rst | set_evt | clr | req_q;

  always_comb begin
    stat_d = stat_q;
    req_d  = req_q;
    seen_d = seen_q;
    if (soft_rst) begin
      stat_d = 1'b0;
      req_d  = 1'b0;
      seen_d = 1'b0;
    end else begin
      // A new event wins over a simultaneous clear.
      if (set_evt)  stat_d = 1'b1;
      else if (clr) stat_d = 1'b0;
      if (set_evt) begin
        req_d  = 1'b1;
        seen_d = 1'b0;
      end else if (req_q && release_now) begin
        req_d  = 1'b0;
        seen_d = 1'b0;
      end else begin
        seen_d = seen_q | (req_q & ack);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      req_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (upd) begin
      stat_q <= stat_d;
      req_q  <= req_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/trig_dma_req.sv
module trig_dma_req #(
  parameter int unsigned GRPS     = trig_dma_pkg::NUM_GRP,
  parameter int unsigned WORD_W   = trig_dma_pkg::WORD_W,
  parameter int unsigned STAT_LSB = trig_dma_pkg::STAT_LSB,
  parameter int unsigned MODE_POS = trig_dma_pkg::MODE_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [GRPS-1:0]   done_evt,
  input  logic [GRPS-1:0]   dma_ack,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [GRPS-1:0]   dma_req
);
  localparam int unsigned STAT_MSB = STAT_LSB + GRPS - 1;

  logic [GRPS-1:0] en_q;
  logic            mode_q;
  logic [GRPS-1:0] stat_q;
  logic [GRPS-1:0] clr_vec;

  assign clr_vec = wr_en ? wr_data[STAT_MSB:STAT_LSB] : '0;

  trig_dma_ctrl_reg #(
    .GRPS(GRPS), .WORD_W(WORD_W), .MODE_POS(MODE_POS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .mode_q(mode_q)
  );

  for (genvar g = 0; g < GRPS; g++) begin : g_lane
    trig_dma_lane u_lane (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .en(en_q[g]), .pulsed(mode_q),
      .evt(done_evt[g]), .clr(clr_vec[g]), .ack(dma_ack[g]),
      .stat_q(stat_q[g]), .req_q(dma_req[g])
    );
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[GRPS-1:0]          = en_q;
    rd_data[STAT_MSB:STAT_LSB] = stat_q;
    rd_data[MODE_POS]          = mode_q;
  end
endmodule

// File: rtl/trig_dma_req_chk.sv
module trig_dma_req_chk #(
  parameter int unsigned GRPS     = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned STAT_LSB = 16,
  parameter int unsigned MODE_POS = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [GRPS-1:0]   done_evt,
  input logic [GRPS-1:0]   dma_ack,
  input logic [WORD_W-1:0] rd_data,
  input logic [GRPS-1:0]   dma_req
);
  logic [GRPS-1:0] en_v, st_v;
  logic            pm;
  assign en_v = rd_data[GRPS-1:0];
  assign st_v = rd_data[STAT_LSB +: GRPS];
  assign pm   = rd_data[MODE_POS];

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dma_req == '0 && rd_data == '0));

  for (genvar g = 0; g < GRPS; g++) begin : g_chk
    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt[g] && en_v[g] && !soft_rst) |=> (st_v[g] && dma_req[g]));
    assert_stat_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_v[g] && !(done_evt[g] && en_v[g])) |=> !st_v[g]);
    assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[g] && st_v[g] && !pm && !soft_rst) |=> dma_req[g]);
    assert_pulsed_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[g] && dma_ack[g] && pm && !soft_rst && !(done_evt[g] && en_v[g])) |=> !dma_req[g]);
  end
endmodule

bind trig_dma_req trig_dma_req_chk #(
  .GRPS(GRPS), .WORD_W(WORD_W), .STAT_LSB(STAT_LSB), .MODE_POS(MODE_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .done_evt(done_evt),
  .dma_ack(dma_ack), .rd_data(rd_data), .dma_req(dma_req)
);

// File: tb/tb_trig_dma_req.sv
module tb_trig_dma_req;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [7:0]  done_evt = '0;
  logic [7:0]  dma_ack = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  dma_req;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  trig_dma_req dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .done_evt(done_evt),
    .dma_ack(dma_ack), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dma_req(dma_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ev(input logic [7:0] m);
    done_evt = m; tick(); done_evt = '0;
  endtask

  task automatic ak(input logic [7:0] m);
    dma_ack = m; tick(); dma_ack = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 dma_req", {24'h0, dma_req}, 32'h0);

    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 8; g++) begin
        logic [7:0]  oh;
        logic [31:0] ew, cw;
        oh = 8'(1 << g);
        ew = (32'(m) << 31) | {24'h0, oh};
        cw = ew | ({24'h0, oh} << 16);

        wr(ew | 32'h7F00_FF00);  // reserved bits written as 1
        chk("R2 readback", rd_data, ew);

        ev(8'hFF);
        chk("R3 status set", {24'h0, rd_data[23:16]}, {24'h0, oh});
        chk("R3 request set", {24'h0, dma_req}, {24'h0, oh});
        chk("R4 disabled groups idle", {24'h0, dma_req & ~oh}, 32'h0);

        ak(oh);
        if (m == 1) begin
          chk("R8 pulsed drop", {24'h0, dma_req}, 32'h0);
          chk("R8 status kept", {24'h0, rd_data[23:16]}, {24'h0, oh});
        end else begin
          chk("R7 held with status set", {24'h0, dma_req}, {24'h0, oh});
        end

        wr(ew);
        chk("R5 zero write keeps", {24'h0, rd_data[23:16]}, {24'h0, oh});

        wr(cw);
        chk("R5 one write clears", {24'h0, rd_data[23:16]}, 32'h0);
        if (m == 0) begin
          chk("R7 drop one edge later", {24'h0, dma_req}, {24'h0, oh});
          tick();
          chk("R7 ack then clear", {24'h0, dma_req}, 32'h0);
        end

        ak(oh);  // ignored, no request up
        ev(oh);
        wr(cw);
        tick(); tick();
        chk("R10 early ack ignored", {24'h0, dma_req}, {24'h0, oh});
        ak(oh);
        chk("R7 clear then ack", {24'h0, dma_req}, 32'h0);

        done_evt = oh; wr_en = 1'b1; wr_data = cw;
        tick();
        done_evt = '0; wr_en = 1'b0; wr_data = '0;
        chk("R6 event beats clear", {24'h0, rd_data[23:16]}, {24'h0, oh});
        wr(cw);
        ak(oh);
        tick();
        chk("R6 cleanup req", {24'h0, dma_req}, 32'h0);
        chk("R6 cleanup status", {24'h0, rd_data[23:16]}, 32'h0);
      end
    end

    wr(32'h8000_00FF);
    ev(8'hFF);
    chk("R9 pre req", {24'h0, dma_req}, 32'hFF);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R9 rd_data", rd_data, 32'h0);
    chk("R9 dma_req", {24'h0, dma_req}, 32'h0);
    ev(8'hFF);
    chk("R9 R4 enables cleared", {24'h0, dma_req}, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule